// File: doc/BRIEF.md
# Double-Buffered Byte Serial Shifter

This block is the transmit half of a byte-to-serial converter that sits beside other shifters in a test-access engine. A host writes bytes into two holding slots. While shifting is enabled, the block sends the oldest held byte out one bit per enable, least significant bit first. A host can therefore load the next byte while the current one is still draining.

The block has no bit counter of its own. The position of the next bit comes from a 3-bit counter that is shared by every parallel shifter, which keeps all of them byte-aligned. If shifting begins while that counter is partway through a byte, only the remaining positions of the first byte are sent. When the shared counter reaches its last position, the slot being sent is released and the other slot becomes the source. A status output tells the host whether at least one slot can accept a byte. A synchronous flush input empties both slots.

Top module: `dbuf_byte_shifter`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `ser_out` is 1, `not_full` is 1 and both slots are empty.
- R2: A byte written while a slot is free is held. Held bytes are sent in the order in which they were accepted, and the two slots are filled and drained alternately.
- R3: `not_full` is 1 exactly when fewer than two bytes are held.
- R4: In a cycle where `shift_en` is 1 and a byte is held, `ser_out` on the next cycle equals bit number `bit_pos` of the oldest held byte. Bit 0 is the least significant bit, so a whole byte is sent LSB first.
- R5: A shift with `bit_pos` equal to 7 releases the oldest byte. The next shift takes its bit from the other slot.
- R6: If shifting starts while `bit_pos` is k, only bits k through 7 of the first byte are sent before that byte is released.
- R7: `ser_out` keeps its value in any cycle where `shift_en` is 0 or no byte is held.
- R8: A write while both slots are held is ignored, unless the oldest byte is released in the same cycle. In that case the new byte is accepted into the slot just released.
- R9: `flush` high at a clock edge empties both slots, sets `ser_out` to 1 and drops any write or shift in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of both slots |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host byte |
| shift_en | input | 1 | Shift one bit this cycle |
| bit_pos | input | 3 | Shared alignment counter value |
| ser_out | output | 1 | Serial data, registered |
| not_full | output | 1 | At least one slot is free |

## Verification
A host write and the release of the oldest byte can happen in the same cycle. The case that matters is when both slots are held, because acceptance then depends on the release. The bench provokes this by filling both slots and then writing exactly on a shift with `bit_pos` at 7. It also mixes random writes and shifts with a random start position, so the collision arises in many states. A bench queue model decides whether the write is accepted, and the serial bits that follow show whether the new byte went behind the remaining one.

// File: rtl/dbuf_shifter_pkg.sv
package dbuf_shifter_pkg;

   // advance a ring index over n entries
   function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int unsigned N     = 2,
   localparam int unsigned IDX_W = (N < 2) ? 1 : $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);
   import dbuf_shifter_pkg::*;

   if (N < 2) begin : g_bad_n
      $error("ring_ptr: N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (flush)
         idx <= '0;
      else if (adv)
         idx <= IDX_W'(ring_next(int'(idx), N));
   end

   a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < N);

endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_BUF = 2,
   localparam int unsigned IDX_W  = $clog2(NUM_BUF)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            wr_fire,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            rd_clear,
   input  logic [IDX_W-1:0]                rd_idx,
   output logic [NUM_BUF-1:0]              slot_valid,
   output logic [NUM_BUF-1:0][DATA_W-1:0]  slot_data
);

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_valid[i] <= 1'b0;
         else if (flush)
            slot_valid[i] <= 1'b0;
         else if (wr_fire && wr_idx == IDX_W'(i))
            slot_valid[i] <= 1'b1;
         else if (rd_clear && rd_idx == IDX_W'(i))
            slot_valid[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_data[i] <= '0;
         else if (!flush && wr_fire && wr_idx == IDX_W'(i))
            slot_data[i] <= wr_data;
      end
   end

   // R2: an accepted write leaves its slot held
   a_r2_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !flush) |=> slot_valid[$past(wr_idx)]);

   // R9: flush empties every slot
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (slot_valid == '0));

endmodule

// File: rtl/dbuf_byte_shifter.sv
module dbuf_byte_shifter #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_BUF    = 2,
   parameter bit          IDLE_LEVEL = 1'b1,
   localparam int unsigned POS_W     = $clog2(DATA_W),
   localparam int unsigned IDX_W     = $clog2(NUM_BUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              shift_en,
   input  logic [POS_W-1:0]  bit_pos,
   output logic              ser_out,
   output logic              not_full
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("dbuf_byte_shifter: DATA_W must be a power of two, at least 2");
   end
   if (NUM_BUF < 2 || (NUM_BUF & (NUM_BUF - 1)) != 0) begin : g_bad_depth
      $error("dbuf_byte_shifter: NUM_BUF must be a power of two, at least 2");
   end

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W - 1);

   logic [NUM_BUF-1:0]             slot_valid;
   logic [NUM_BUF-1:0][DATA_W-1:0] slot_data;
   logic [IDX_W-1:0]               wr_idx;
   logic [IDX_W-1:0]               rd_idx;
   logic                           head_valid;
   logic [DATA_W-1:0]              head_byte;
   logic                           drain;
   logic                           wr_fire;
   logic                           shift_fire;

   assign head_valid = slot_valid[rd_idx];
   assign head_byte  = slot_data[rd_idx];
   assign shift_fire = !flush && shift_en && head_valid;
   assign drain      = shift_fire && (bit_pos == LAST_POS);
   assign wr_fire    = !flush && wr_en &&
                       (!slot_valid[wr_idx] || (drain && rd_idx == wr_idx));

   slot_bank #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .wr_fire    (wr_fire),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .rd_clear   (drain),
      .rd_idx     (rd_idx),
      .slot_valid (slot_valid),
      .slot_data  (slot_data)
   );

   ring_ptr #(.N(NUM_BUF)) u_wr_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .adv   (wr_fire),
      .idx   (wr_idx)
   );

   ring_ptr #(.N(NUM_BUF)) u_rd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .adv   (drain),
      .idx   (rd_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ser_out <= IDLE_LEVEL;
      else if (flush)
         ser_out <= IDLE_LEVEL;
      else if (shift_fire)
         ser_out <= head_byte[bit_pos];
   end

   assign not_full = ~&slot_valid;

   // R7: no shift, no change on the serial line
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !shift_fire) |=> $stable(ser_out));

   // R9: flush drives the idle level and frees space
   a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ser_out == IDLE_LEVEL && not_full));

   // R5: a release without a refill frees a slot
   a_r5_drain_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && !wr_fire) |=> not_full);

   // R8: a blocked write leaves occupancy unchanged
   a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !not_full && wr_en && !drain) |=> !not_full);

endmodule

// File: tb/dbuf_byte_shifter_tb.sv
module dbuf_byte_shifter_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       shift_en = 1'b0;
   logic [2:0] bit_pos = 3'd0;
   logic       ser_out;
   logic       not_full;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] mq[$];
   logic       e_ser = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbuf_byte_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
      .wr_data(wr_data), .shift_en(shift_en), .bit_pos(bit_pos),
      .ser_out(ser_out), .not_full(not_full)
   );

   function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] p);
      return b[p];
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, update model, check at next negedge
   task automatic step(input logic w, input logic [7:0] d, input logic s,
                       input logic f, input string tag);
      logic drn;
      logic wok;
      wr_en = w; wr_data = d; shift_en = s; flush = f;
      drn = !f && s && mq.size() > 0 && bit_pos == 3'd7;
      wok = !f && w && (mq.size() < 2 || drn);
      if (f) e_ser = 1'b1;
      else if (s && mq.size() > 0) e_ser = pick_bit(mq[0], bit_pos);
      if (f) mq.delete();
      else begin
         if (drn) void'(mq.pop_front());
         if (wok) mq.push_back(d);
      end
      @(posedge clk);
      #1;
      if (s) bit_pos = bit_pos + 3'd1;
      @(negedge clk);
      check({tag, " ser_out"}, ser_out, e_ser);
      check({tag, " not_full (R3)"}, not_full, mq.size() < 2);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = 32'h5eed_0c3a;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ser_out", ser_out, 1'b1);
      check("R1 not_full", not_full, 1'b1);

      // R6: start mid-byte at position 3
      bit_pos = 3'd3;
      step(1, 8'hA5, 0, 0, "R2");
      for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0, "R6");
      check("R6 released after five bits", not_full, 1'b1);
      // R7: shifting with nothing held leaves line unchanged
      for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, "R7");
      check("R7 queue empty", ser_out, 1'b1);

      // fill both, third write ignored (R8)
      bit_pos = 3'd0;
      step(1, 8'h3C, 0, 0, "R2");
      step(1, 8'hC3, 0, 0, "R2");
      step(1, 8'hFF, 0, 0, "R8");
      check("R8 full", not_full, 1'b0);
      // drain first byte; write at pos 7 collides with release (R8/R5)
      for (int i = 0; i < 7; i++) step(0, 8'h00, 1, 0, "R4");
      step(1, 8'h81, 1, 0, "R8");
      check("R8 refill on release keeps full", not_full, 1'b0);
      for (int i = 0; i < 16; i++) step(0, 8'h00, 1, 0, "R5");
      check("R5 both released", not_full, 1'b1);

      // R9: flush with data held
      step(1, 8'h5A, 0, 0, "R2");
      step(0, 8'h00, 1, 0, "R4");
      step(1, 8'h11, 1, 1, "R9");
      check("R9 idle level", ser_out, 1'b1);

      // random traffic
      bit_pos = 3'($urandom_range(0, 7));
      for (int i = 0; i < 3000; i++) begin
         step(($urandom_range(0, 99) < 40), 8'($urandom), ($urandom_range(0, 99) < 70),
              ($urandom_range(0, 999) < 5), "R4");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule